// File: doc/BRIEF.md
# Program-Flow Context Unit

This block keeps the program-flow state of a small 8-bit core. It holds a 12-bit program counter, a six-level return stack that shifts as a whole, and three banked carry/zero pairs, one for each execution context: normal, interrupt and non-maskable interrupt (NMI). The instruction decoder drives one command per cycle, together with a target address, a vector or a signed offset. The block answers with the current PC, the carry/zero pair of the active context and the context code.

The return stack has no pointer. A push moves every level one place deeper, so once all six levels are full the oldest return address falls off. A pop moves every level one place up. A pop on an empty stack changes nothing, and the PC steps on by one. A second shift history, six entries of context codes, records the context in force at each interrupt or NMI entry, so that return-from-interrupt restores the right flag pair after nested entries.

The context is a three-state machine with the states CTX_NORMAL, CTX_INT and CTX_NMI. It has these transitions:
- Reset or a reset command enters CTX_NMI.
- An interrupt entry enters CTX_INT.
- An NMI entry enters CTX_NMI.
- A return-from-interrupt moves to the state popped from the history, or to CTX_NORMAL when the history is empty.
- Every other command keeps the state.

Top module: `pc_ctx_unit`

## Requirements
- R1: After `rst_n` low or command 9 (reset), the PC is 0xFFE, the context is NMI (code 2) and both stacks are empty. Only `rst_n` also clears all three flag pairs to 0.
- R2: Command 1 (increment) loads PC+1, wrapping from 0xFFF to 0x000. Command 0 (hold), and any code above 9, leaves the PC unchanged.
- R3: Command 2 (jump) loads `target_i`. Command 3 (branch) adds the sign-extended 8-bit `offset_i` to the PC, modulo 4096.
- R4: Command 4 (call) pushes PC+1 and loads `target_i`. Command 7 (return) loads the newest stacked address and removes it from the stack.
- R5: A push onto a full stack of six entries discards the oldest entry and keeps the six newest.
- R6: A return (7) or return-from-interrupt (8) on an empty stack loads PC+1 and leaves the stack empty.
- R7: Command 5 (interrupt entry) pushes the current PC, loads `target_i` and selects context 1. Command 6 (NMI entry) does the same but selects context 2.
- R8: Command 8 (return-from-interrupt) pops the PC and restores the context that was active at the matching entry. With an empty history it selects context 0 (normal).
- R9: Flag writes (`c_we_i`, `z_we_i`) change only the pair of the context active in that cycle. A pair keeps its values across any number of context switches.
- R10: A plain return (7) leaves the context unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 4 | Command code for this cycle |
| target_i | input | 12 | Jump/call target or interrupt vector |
| offset_i | input | 8 | Signed branch offset |
| c_we_i | input | 1 | Write enable for the active carry flag |
| c_i | input | 1 | New carry value |
| z_we_i | input | 1 | Write enable for the active zero flag |
| z_i | input | 1 | New zero value |
| pc_o | output | 12 | Current program counter |
| carry_o | output | 1 | Carry of the active pair |
| zero_o | output | 1 | Zero of the active pair |
| ctx_o | output | 2 | Active context: 0 normal, 1 interrupt, 2 NMI |

## Verification
A fault in the return stack stays hidden until a return uses the damaged level. A lost or shifted entry shows up as a wrong `pc_o` one cycle after the return that reads it, which can be many commands after the fault. A fault in the context history shows up as a wrong `ctx_o`, and usually also a wrong flag pair, one cycle after a return-from-interrupt. A flag written into the wrong bank is visible at `carry_o`/`zero_o` only once the context moves back to that bank, so the tests leave marks in each pair and then come back to them across nested entries.

// File: rtl/pc_ctx_pkg.sv
package pc_ctx_pkg;
    typedef enum logic [3:0] {
        CMD_HOLD   = 4'd0,
        CMD_INC    = 4'd1,
        CMD_JUMP   = 4'd2,
        CMD_BRANCH = 4'd3,
        CMD_CALL   = 4'd4,
        CMD_INT    = 4'd5,
        CMD_NMI    = 4'd6,
        CMD_RET    = 4'd7,
        CMD_RETI   = 4'd8,
        CMD_RESET  = 4'd9
    } cmd_e;

    typedef enum logic [1:0] {
        CTX_NORMAL = 2'd0,
        CTX_INT    = 2'd1,
        CTX_NMI    = 2'd2
    } ctx_e;

    localparam int NUM_CTX = 3;
endpackage

// File: rtl/shift_stack.sv
module shift_stack #(
    parameter int WIDTH = 12,
    parameter int DEPTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] top,
    output logic             empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] level_q [DEPTH];
    logic [CNT_W-1:0] count_q;

    assign top   = level_q[0];
    assign empty = (count_q == '0);

    // Level 0 takes the pushed value; deeper levels copy their neighbours.
    for (genvar i = 0; i < DEPTH; i++) begin : g_level
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                level_q[i] <= '0;
            end else if (clr) begin
                level_q[i] <= '0;
            end else if (push) begin
                if (i == 0) level_q[i] <= din;
                else        level_q[i] <= level_q[(i == 0) ? 0 : i-1];
            end else if (pop && !empty) begin
                if (i == DEPTH-1) level_q[i] <= '0;
                else              level_q[i] <= level_q[(i == DEPTH-1) ? i : i+1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (push) begin
            if (count_q != CNT_W'(DEPTH)) count_q <= count_q + 1'b1;
        end else if (pop && !empty) begin
            count_q <= count_q - 1'b1;
        end
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr && count_q == CNT_W'(DEPTH)) |=> (count_q == CNT_W'(DEPTH)));

    // R6
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !clr && empty) |=> (empty && $stable(top)));
endmodule

// File: rtl/flag_bank.sv
module flag_bank
    import pc_ctx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ctx_e sel,
    input  logic c_we,
    input  logic c_in,
    input  logic z_we,
    input  logic z_in,
    output logic c_out,
    output logic z_out
);
    logic [NUM_CTX-1:0] c_q;
    logic [NUM_CTX-1:0] z_q;

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_pair
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                c_q[i] <= 1'b0;
                z_q[i] <= 1'b0;
            end else if (sel == ctx_e'(i)) begin
                if (c_we) c_q[i] <= c_in;
                if (z_we) z_q[i] <= z_in;
            end
        end

        // R9
        idle_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel != ctx_e'(i)) |=> ($stable(c_q[i]) && $stable(z_q[i])));
    end

    always_comb begin
        c_out = 1'b0;
        z_out = 1'b0;
        unique case (sel)
            CTX_NORMAL: begin c_out = c_q[0]; z_out = z_q[0]; end
            CTX_INT:    begin c_out = c_q[1]; z_out = z_q[1]; end
            CTX_NMI:    begin c_out = c_q[2]; z_out = z_q[2]; end
            default:    begin c_out = 1'b0;   z_out = 1'b0;   end
        endcase
    end
endmodule

// File: rtl/pc_ctx_unit.sv
module pc_ctx_unit
    import pc_ctx_pkg::*;
#(
    parameter int          PC_W      = 12,
    parameter int          OFF_W     = 8,
    parameter int          DEPTH     = 6,
    parameter logic [11:0] RESET_VEC = 12'hFFE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       cmd_i,
    input  logic [PC_W-1:0]  target_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic             c_we_i,
    input  logic             c_i,
    input  logic             z_we_i,
    input  logic             z_i,
    output logic [PC_W-1:0]  pc_o,
    output logic             carry_o,
    output logic             zero_o,
    output logic [1:0]       ctx_o
);
    localparam logic [PC_W-1:0] RST_PC = PC_W'(RESET_VEC);

    cmd_e            cmd;
    ctx_e            ctx_q, ctx_d;
    logic [PC_W-1:0] pc_q, pc_d;
    logic [PC_W-1:0] pc_inc, pc_rel;

    logic            ret_push, ret_pop, ret_empty;
    logic [PC_W-1:0] ret_din, ret_top;
    logic            hist_push, hist_pop, hist_empty, stk_clr;
    logic [1:0]      hist_top;

    assign cmd    = cmd_e'(cmd_i);
    assign pc_inc = pc_q + 1'b1;
    assign pc_rel = pc_q + {{(PC_W-OFF_W){offset_i[OFF_W-1]}}, offset_i};

    // State register: context and program counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= CTX_NMI;
            pc_q  <= RST_PC;
        end else begin
            ctx_q <= ctx_d;
            pc_q  <= pc_d;
        end
    end

    // Next state and stack controls
    always_comb begin
        ctx_d     = ctx_q;
        pc_d      = pc_q;
        ret_push  = 1'b0;
        ret_pop   = 1'b0;
        ret_din   = pc_q;
        hist_push = 1'b0;
        hist_pop  = 1'b0;
        stk_clr   = 1'b0;
        case (cmd)
            CMD_INC:    pc_d = pc_inc;
            CMD_JUMP:   pc_d = target_i;
            CMD_BRANCH: pc_d = pc_rel;
            CMD_CALL: begin
                ret_push = 1'b1;
                ret_din  = pc_inc;
                pc_d     = target_i;
            end
            CMD_INT, CMD_NMI: begin
                ret_push  = 1'b1;
                hist_push = 1'b1;
                pc_d      = target_i;
                ctx_d     = (cmd == CMD_INT) ? CTX_INT : CTX_NMI;
            end
            CMD_RET, CMD_RETI: begin
                ret_pop = 1'b1;
                pc_d    = ret_empty ? pc_inc : ret_top;
                if (cmd == CMD_RETI) begin
                    hist_pop = 1'b1;
                    unique case (ctx_q)
                        CTX_NORMAL, CTX_INT, CTX_NMI:
                            ctx_d = hist_empty ? CTX_NORMAL : ctx_e'(hist_top);
                        default: ctx_d = CTX_NORMAL;
                    endcase
                end
            end
            CMD_RESET: begin
                stk_clr = 1'b1;
                pc_d    = RST_PC;
                ctx_d   = CTX_NMI;
            end
            default: pc_d = pc_q;
        endcase
    end

    shift_stack #(.WIDTH(PC_W), .DEPTH(DEPTH)) u_ret (
        .clk(clk), .rst_n(rst_n), .clr(stk_clr), .push(ret_push), .pop(ret_pop),
        .din(ret_din), .top(ret_top), .empty(ret_empty)
    );

    shift_stack #(.WIDTH(2), .DEPTH(DEPTH)) u_hist (
        .clk(clk), .rst_n(rst_n), .clr(stk_clr), .push(hist_push), .pop(hist_pop),
        .din(ctx_q), .top(hist_top), .empty(hist_empty)
    );

    flag_bank u_flags (
        .clk(clk), .rst_n(rst_n), .sel(ctx_q),
        .c_we(c_we_i), .c_in(c_i), .z_we(z_we_i), .z_in(z_i),
        .c_out(carry_o), .z_out(zero_o)
    );

    // Outputs
    always_comb begin
        pc_o  = pc_q;
        ctx_o = ctx_q;
    end

    // R2
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 4'd1) |=> (pc_o == PC_W'($past(pc_o) + 1'b1)));

    // R1
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 4'd9) |=> (pc_o == RST_PC && ctx_o == 2'd2));

    // R7
    int_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 4'd5) |=> (ctx_o == 2'd1 && pc_o == $past(target_i)));

    // R10
    ret_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 4'd7) |=> $stable(ctx_o));
endmodule

// File: tb/tb_pc_ctx_unit.sv
`timescale 1ns/1ps
module tb_pc_ctx_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cmd_i = '0;
    logic [11:0] target_i = '0;
    logic [7:0]  offset_i = '0;
    logic        c_we_i = 1'b0, c_i = 1'b0, z_we_i = 1'b0, z_i = 1'b0;
    logic [11:0] pc_o;
    logic        carry_o, zero_o;
    logic [1:0]  ctx_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    pc_ctx_unit dut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .target_i(target_i), .offset_i(offset_i),
        .c_we_i(c_we_i), .c_i(c_i), .z_we_i(z_we_i), .z_i(z_i),
        .pc_o(pc_o), .carry_o(carry_o), .zero_o(zero_o), .ctx_o(ctx_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] c, input logic [11:0] t, input logic [7:0] o);
        @(negedge clk);
        cmd_i = c; target_i = t; offset_i = o;
        c_we_i = 1'b0; z_we_i = 1'b0;
        @(posedge clk); #1;
        cmd_i = 4'd0;
    endtask

    task automatic set_flags(input logic c, input logic z);
        @(negedge clk);
        cmd_i = 4'd0; c_we_i = 1'b1; c_i = c; z_we_i = 1'b1; z_i = z;
        @(posedge clk); #1;
        c_we_i = 1'b0; z_we_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 pc", pc_o, 12'hFFE);
        chk("R1 ctx", ctx_o, 2);
        chk("R1 flags", {carry_o, zero_o}, 0);
    endtask

    task automatic t_inc_hold();
        step(4'd2, 12'hFFF, 0);
        step(4'd1, 0, 0);
        chk("R2 wrap", pc_o, 12'h000);
        step(4'd1, 0, 0);
        chk("R2 inc", pc_o, 12'h001);
        step(4'd0, 12'h555, 0);
        chk("R2 hold", pc_o, 12'h001);
        step(4'd15, 12'h555, 0);
        chk("R2 unused code", pc_o, 12'h001);
    endtask

    task automatic t_branch();
        step(4'd2, 12'h010, 0);
        chk("R3 jump", pc_o, 12'h010);
        step(4'd3, 0, 8'hFD);
        chk("R3 back", pc_o, 12'h00D);
        step(4'd2, 12'hFFE, 0);
        step(4'd3, 0, 8'h05);
        chk("R3 wrap", pc_o, 12'h003);
        step(4'd3, 0, 8'h80);
        chk("R3 min", pc_o, 12'hF83);
    endtask

    task automatic t_call_ret();
        step(4'd2, 12'h100, 0);
        step(4'd4, 12'h200, 0);
        chk("R4 call", pc_o, 12'h200);
        step(4'd4, 12'h300, 0);
        step(4'd7, 0, 0);
        chk("R4 ret1", pc_o, 12'h201);
        step(4'd7, 0, 0);
        chk("R4 ret2", pc_o, 12'h101);
    endtask

    task automatic t_overflow();
        step(4'd9, 0, 0);
        step(4'd2, 12'h000, 0);
        for (int k = 1; k <= 7; k++) step(4'd4, 12'(16 * k), 0);
        for (int k = 6; k >= 1; k--) begin
            step(4'd7, 0, 0);
            chk("R5 pop", pc_o, 12'(16 * k + 1));
        end
        step(4'd7, 0, 0);
        chk("R5 oldest lost R6", pc_o, 12'h012);
    endtask

    task automatic t_underflow();
        step(4'd9, 0, 0);
        chk("R1 soft pc", pc_o, 12'hFFE);
        chk("R1 soft ctx", ctx_o, 2);
        step(4'd7, 0, 0);
        chk("R6 ret empty", pc_o, 12'hFFF);
        step(4'd7, 0, 0);
        chk("R6 ret empty again", pc_o, 12'h000);
        step(4'd4, 12'h050, 0);
        step(4'd7, 0, 0);
        chk("R6 stack still usable", pc_o, 12'h001);
    endtask

    task automatic t_contexts();
        step(4'd9, 0, 0);
        set_flags(1'b1, 1'b1);
        chk("R9 nmi pair", {carry_o, zero_o}, 2'b11);
        step(4'd8, 0, 0);
        chk("R8 empty to normal", ctx_o, 0);
        chk("R6 reti empty pc", pc_o, 12'hFFF);
        chk("R9 normal pair", {carry_o, zero_o}, 2'b00);
        set_flags(1'b1, 1'b0);
        step(4'd5, 12'h080, 0);
        chk("R7 int ctx", ctx_o, 1);
        chk("R7 int pc", pc_o, 12'h080);
        chk("R9 int pair", {carry_o, zero_o}, 2'b00);
        set_flags(1'b0, 1'b1);
        step(4'd4, 12'h0A0, 0);
        step(4'd7, 0, 0);
        chk("R10 ret keeps ctx", ctx_o, 1);
        chk("R4 ret in int", pc_o, 12'h081);
        step(4'd6, 12'h0C0, 0);
        chk("R7 nmi ctx", ctx_o, 2);
        chk("R9 nmi kept", {carry_o, zero_o}, 2'b11);
        step(4'd8, 0, 0);
        chk("R8 back to int", ctx_o, 1);
        chk("R8 pc", pc_o, 12'h081);
        chk("R9 int kept", {carry_o, zero_o}, 2'b01);
        step(4'd8, 0, 0);
        chk("R8 back to normal", ctx_o, 0);
        chk("R8 pc normal", pc_o, 12'hFFF);
        chk("R9 normal kept", {carry_o, zero_o}, 2'b10);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_inc_hold();
        t_branch();
        t_call_ret();
        t_overflow();
        t_underflow();
        t_contexts();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule